// File: doc/BRIEF.md
# Scan-Cycle I/O Image Controller

This block drives the repeating scan of a programmable controller. Every scan passes through five phases in a fixed order: a self-test step, a communication service step, an input sampling step, a program execution step and an output refresh step. Field inputs are captured into an input image once per scan. An external logic engine reads that frozen image during execution and writes its results into an output image. Those results reach the field terminals only when the refresh step copies the output image into the output latch.

A scan watchdog counts the cycles of each scan. It is cleared in the self-test step. If one scan runs too long, the block raises an alarm and halts. A fatal fault reported during self-test also halts the block and lights a fault indicator. Once halted, the block stays halted until it is reset, and after the reset it needs a new run request before it scans again. The communication engine and the execution engine are outside the block and talk to it through simple done handshakes.

The sequencer has seven states: IDLE, SELFTEST, COMM, INPUT, EXEC, OUTPUT and STOP. The transitions are:
- IDLE→SELFTEST on a run request.
- SELFTEST→COMM when there is no fault, and SELFTEST→STOP on a fatal fault.
- COMM→INPUT when the engine reports done or when no request is pending.
- INPUT→EXEC always.
- EXEC→OUTPUT when the execution engine reports done.
- OUTPUT→SELFTEST always.
- Any counted state→STOP when the watchdog expires.

Top module: `scan_io_ctrl`

## Requirements
- R1: `phase_o` encodes IDLE=0, SELFTEST=1, COMM=2, INPUT=3, EXEC=4, OUTPUT=5, STOP=6. After reset the block sits in IDLE until `run_req` is high there. A scan then runs SELFTEST, COMM, INPUT, EXEC, OUTPUT and goes back to SELFTEST.
- R2: COMM lasts exactly one cycle when `comm_pending` is low. When `comm_pending` is high, COMM holds with `comm_busy` high until `comm_done` is seen.
- R3: The input image loads all of `field_in` at the clock edge that ends INPUT and then holds for the whole scan. `in_rd_bit` returns bit `in_rd_idx` of the image, never the live terminal value.
- R4: A write (`out_wr_en`, `out_wr_idx`, `out_wr_bit`) updates the output image only in EXEC and is ignored in every other state. `out_rd_bit` returns bit `out_rd_idx` of the output image in the cycle after a write.
- R5: `field_out` changes only at the edge that ends OUTPUT, where it takes the output image. It holds that value between refreshes.
- R6: EXEC lasts until `exec_done` is high, however many cycles that takes, as long as the watchdog does not expire.
- R7: Counting begins in the cycle after SELFTEST. A scan whose non-self-test states take WDOG_LIMIT−1 cycles completes normally. A scan that reaches a WDOG_LIMIT-th such cycle expires in that cycle.
- R8: On expiry the block enters STOP at the next edge, with `wdog_alarm`=1 and `stop_by_wdog`=1. The output refresh of that scan is dropped.
- R9: `fault_fatal` high in SELFTEST sends the block to STOP with `fault_led`=1 and `stop_by_wdog`=0. `fault_fatal` in other states has no effect.
- R10: In STOP, `run_req` and writes are ignored and `field_out` keeps its last value. Only reset leaves STOP.
- R11: Reset clears the images, the latch, `wdog_alarm`, `fault_led` and `stop_by_wdog`, and returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Request to start scanning from IDLE |
| fault_fatal | input | 1 | Fatal fault report, sampled in SELFTEST |
| comm_pending | input | 1 | Communication work is waiting |
| comm_done | input | 1 | Communication engine finished |
| exec_done | input | 1 | Execution engine finished the program |
| field_in | input | N_IN | Live input terminals |
| in_rd_idx | input | IN_IDX_W | Input image read index |
| in_rd_bit | output | 1 | Input image bit at `in_rd_idx` |
| out_wr_en | input | 1 | Output image write strobe |
| out_wr_idx | input | OUT_IDX_W | Output image write index |
| out_wr_bit | input | 1 | Output image write data |
| out_rd_idx | input | OUT_IDX_W | Output image read index |
| out_rd_bit | output | 1 | Output image bit at `out_rd_idx` |
| field_out | output | N_OUT | Output latch driving terminals |
| phase_o | output | 3 | Current sequencer state |
| comm_busy | output | 1 | COMM with pending work |
| exec_active | output | 1 | EXEC in progress |
| stopped | output | 1 | Block is in STOP |
| wdog_alarm | output | 1 | Sticky watchdog alarm |
| fault_led | output | 1 | Sticky fatal-fault indicator |
| stop_by_wdog | output | 1 | STOP cause: 1 watchdog, 0 fault |

## Verification
The bench changes the terminals while EXEC is running. A design that read the live inputs, or reloaded the image outside INPUT, would return the new pattern instead of the frozen one. It runs two scans that differ by one cycle around the watchdog limit. An off-by-one counter would either halt the good scan or let the overrunning one refresh its outputs. It also issues writes during COMM, OUTPUT and STOP, and raises a fault outside SELFTEST; a design that accepted any of these would show it through `out_rd_bit`, `field_out` or `fault_led`. Finally it checks that STOP survives a run request and that a reset alone does not restart scanning.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SELFTEST = 3'd1,
        PH_COMM     = 3'd2,
        PH_INPUT    = 3'd3,
        PH_EXEC     = 3'd4,
        PH_OUTPUT   = 3'd5,
        PH_STOP     = 3'd6
    } phase_e;

endpackage

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_req,
    input  logic   fault_fatal,
    input  logic   comm_pending,
    input  logic   comm_done,
    input  logic   exec_done,
    input  logic   wd_expire,
    output phase_e phase,
    output logic   comm_busy,
    output logic   exec_active,
    output logic   sample_en,
    output logic   refresh_en,
    output logic   wd_clear,
    output logic   wd_count_en,
    output logic   stopped,
    output logic   fault_led,
    output logic   wdog_alarm,
    output logic   stop_by_wdog
);

    phase_e state_q;
    phase_e state_d;
    logic   overrun;

    assign overrun = wd_count_en && wd_expire;
    assign phase   = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:     if (run_req) state_d = PH_SELFTEST;
            PH_SELFTEST: state_d = fault_fatal ? PH_STOP : PH_COMM;
            PH_COMM:     if (!comm_pending || comm_done) state_d = PH_INPUT;
            PH_INPUT:    state_d = PH_EXEC;
            PH_EXEC:     if (exec_done) state_d = PH_OUTPUT;
            PH_OUTPUT:   state_d = PH_SELFTEST;
            PH_STOP:     state_d = PH_STOP;
            default:     state_d = PH_STOP;
        endcase
        if (overrun) begin
            state_d = PH_STOP;
        end
    end

    // per-state outputs
    always_comb begin
        comm_busy   = 1'b0;
        exec_active = 1'b0;
        sample_en   = 1'b0;
        refresh_en  = 1'b0;
        wd_clear    = 1'b0;
        wd_count_en = 1'b0;
        stopped     = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
            end
            PH_SELFTEST: begin
                wd_clear = 1'b1;
            end
            PH_COMM: begin
                comm_busy   = comm_pending;
                wd_count_en = 1'b1;
            end
            PH_INPUT: begin
                sample_en   = 1'b1;
                wd_count_en = 1'b1;
            end
            PH_EXEC: begin
                exec_active = 1'b1;
                wd_count_en = 1'b1;
            end
            PH_OUTPUT: begin
                refresh_en  = !wd_expire;
                wd_count_en = 1'b1;
            end
            PH_STOP: begin
                stopped = 1'b1;
            end
            default: begin
                stopped = 1'b1;
            end
        endcase
    end

    // sticky halt cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_led    <= 1'b0;
            wdog_alarm   <= 1'b0;
            stop_by_wdog <= 1'b0;
        end else if (state_q == PH_SELFTEST && fault_fatal) begin
            fault_led    <= 1'b1;
            stop_by_wdog <= 1'b0;
        end else if (overrun) begin
            wdog_alarm   <= 1'b1;
            stop_by_wdog <= 1'b1;
        end
    end

endmodule

// File: rtl/scan_wdog.sv
module scan_wdog #(
    parameter int WDOG_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic expire
);

    localparam int CW = $clog2(WDOG_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(WDOG_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scan_image.sv
module scan_image #(
    parameter int N_IN  = 16,
    parameter int N_OUT = 16,
    localparam int IN_IDX_W  = $clog2(N_IN),
    localparam int OUT_IDX_W = $clog2(N_OUT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic                 write_ok,
    input  logic                 refresh_en,
    input  logic [N_IN-1:0]      field_in,
    input  logic [IN_IDX_W-1:0]  in_rd_idx,
    output logic                 in_rd_bit,
    input  logic                 wr_en,
    input  logic [OUT_IDX_W-1:0] wr_idx,
    input  logic                 wr_bit,
    input  logic [OUT_IDX_W-1:0] out_rd_idx,
    output logic                 out_rd_bit,
    output logic [N_OUT-1:0]     field_out
);

    logic [N_IN-1:0]  in_img;
    logic [N_OUT-1:0] out_img;
    logic [N_OUT-1:0] out_lat;
    logic             wr_go;

    assign wr_go = wr_en && write_ok;

    // input image: whole-word capture in the sampling phase only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_img <= '0;
        end else if (sample_en) begin
            in_img <= field_in;
        end
    end

    // output image bit and its latch, one slice per terminal
    for (genvar b = 0; b < N_OUT; b++) begin : g_obit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_img[b] <= 1'b0;
                out_lat[b] <= 1'b0;
            end else begin
                if (wr_go && (int'(wr_idx) == b)) begin
                    out_img[b] <= wr_bit;
                end
                if (refresh_en) begin
                    out_lat[b] <= out_img[b];
                end
            end
        end
    end

    assign in_rd_bit  = (int'(in_rd_idx) < N_IN) ? in_img[in_rd_idx] : 1'b0;
    assign out_rd_bit = (int'(out_rd_idx) < N_OUT) ? out_img[out_rd_idx] : 1'b0;
    assign field_out  = out_lat;

endmodule

// File: rtl/scan_io_ctrl.sv
module scan_io_ctrl
    import scan_pkg::*;
#(
    parameter int N_IN       = 16,
    parameter int N_OUT      = 16,
    parameter int WDOG_LIMIT = 1000,
    localparam int IN_IDX_W  = $clog2(N_IN),
    localparam int OUT_IDX_W = $clog2(N_OUT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_req,
    input  logic                 fault_fatal,
    input  logic                 comm_pending,
    input  logic                 comm_done,
    input  logic                 exec_done,
    input  logic [N_IN-1:0]      field_in,
    input  logic [IN_IDX_W-1:0]  in_rd_idx,
    output logic                 in_rd_bit,
    input  logic                 out_wr_en,
    input  logic [OUT_IDX_W-1:0] out_wr_idx,
    input  logic                 out_wr_bit,
    input  logic [OUT_IDX_W-1:0] out_rd_idx,
    output logic                 out_rd_bit,
    output logic [N_OUT-1:0]     field_out,
    output logic [2:0]           phase_o,
    output logic                 comm_busy,
    output logic                 exec_active,
    output logic                 stopped,
    output logic                 wdog_alarm,
    output logic                 fault_led,
    output logic                 stop_by_wdog
);

    phase_e phase;
    logic   sample_en;
    logic   refresh_en;
    logic   wd_clear;
    logic   wd_count_en;
    logic   wd_expire;

    scan_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_req      (run_req),
        .fault_fatal  (fault_fatal),
        .comm_pending (comm_pending),
        .comm_done    (comm_done),
        .exec_done    (exec_done),
        .wd_expire    (wd_expire),
        .phase        (phase),
        .comm_busy    (comm_busy),
        .exec_active  (exec_active),
        .sample_en    (sample_en),
        .refresh_en   (refresh_en),
        .wd_clear     (wd_clear),
        .wd_count_en  (wd_count_en),
        .stopped      (stopped),
        .fault_led    (fault_led),
        .wdog_alarm   (wdog_alarm),
        .stop_by_wdog (stop_by_wdog)
    );

    scan_wdog #(.WDOG_LIMIT(WDOG_LIMIT)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wd_clear),
        .count_en (wd_count_en),
        .expire   (wd_expire)
    );

    scan_image #(.N_IN(N_IN), .N_OUT(N_OUT)) u_img (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .write_ok   (exec_active),
        .refresh_en (refresh_en),
        .field_in   (field_in),
        .in_rd_idx  (in_rd_idx),
        .in_rd_bit  (in_rd_bit),
        .wr_en      (out_wr_en),
        .wr_idx     (out_wr_idx),
        .wr_bit     (out_wr_bit),
        .out_rd_idx (out_rd_idx),
        .out_rd_bit (out_rd_bit),
        .field_out  (field_out)
    );

    assign phase_o = phase;

endmodule

// File: rtl/scan_io_ctrl_chk.sv
module scan_io_ctrl_chk
    import scan_pkg::*;
#(
    parameter int N_OUT      = 16,
    parameter int WDOG_LIMIT = 1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       phase_o,
    input logic             fault_fatal,
    input logic             exec_done,
    input logic             comm_busy,
    input logic [N_OUT-1:0] field_out,
    input logic             stopped,
    input logic             wdog_alarm,
    input logic             fault_led,
    input logic             stop_by_wdog
);

    logic        counted;
    logic [31:0] span;

    assign counted = (phase_o == PH_COMM) || (phase_o == PH_INPUT) ||
                     (phase_o == PH_EXEC) || (phase_o == PH_OUTPUT);

    // independent scan-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span <= '0;
        end else if (phase_o == PH_SELFTEST) begin
            span <= '0;
        end else if (counted) begin
            span <= span + 1;
        end
    end

    assert_input_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_INPUT) |=> (phase_o == PH_EXEC || phase_o == PH_STOP));

    assert_output_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_OUTPUT) |=> (phase_o == PH_SELFTEST || phase_o == PH_STOP));

    assert_busy_in_comm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        comm_busy |-> (phase_o == PH_COMM));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != PH_OUTPUT) |=> $stable(field_out));

    assert_exec_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EXEC && !exec_done && span < 32'(WDOG_LIMIT - 1)) |=> (phase_o == PH_EXEC));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        counted |-> (span < 32'(WDOG_LIMIT)));

    assert_alarm_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_alarm |-> (stopped && stop_by_wdog));

    assert_fault_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_SELFTEST && fault_fatal) |=> (stopped && fault_led && !stop_by_wdog));

    assert_stop_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped);

endmodule

bind scan_io_ctrl scan_io_ctrl_chk #(
    .N_OUT      (N_OUT),
    .WDOG_LIMIT (WDOG_LIMIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_o      (phase_o),
    .fault_fatal  (fault_fatal),
    .exec_done    (exec_done),
    .comm_busy    (comm_busy),
    .field_out    (field_out),
    .stopped      (stopped),
    .wdog_alarm   (wdog_alarm),
    .fault_led    (fault_led),
    .stop_by_wdog (stop_by_wdog)
);

// File: tb/scan_io_ctrl_test.sv
module scan_io_ctrl_test;
    import scan_pkg::*;

    localparam int NI  = 8;
    localparam int NO  = 8;
    localparam int LIM = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_req, fault_fatal, comm_pending, comm_done, exec_done;
    logic [NI-1:0] field_in;
    logic [2:0]    in_rd_idx, out_wr_idx, out_rd_idx;
    logic          out_wr_en, out_wr_bit;
    logic          in_rd_bit, out_rd_bit;
    logic [NO-1:0] field_out;
    logic [2:0]    phase_o;
    logic          comm_busy, exec_active, stopped, wdog_alarm, fault_led, stop_by_wdog;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    scan_io_ctrl #(.N_IN(NI), .N_OUT(NO), .WDOG_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .fault_fatal(fault_fatal),
        .comm_pending(comm_pending), .comm_done(comm_done), .exec_done(exec_done),
        .field_in(field_in), .in_rd_idx(in_rd_idx), .in_rd_bit(in_rd_bit),
        .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx), .out_wr_bit(out_wr_bit),
        .out_rd_idx(out_rd_idx), .out_rd_bit(out_rd_bit), .field_out(field_out),
        .phase_o(phase_o), .comm_busy(comm_busy), .exec_active(exec_active),
        .stopped(stopped), .wdog_alarm(wdog_alarm), .fault_led(fault_led),
        .stop_by_wdog(stop_by_wdog)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic write_bit(input int idx, input logic val);
        out_wr_en  = 1'b1;
        out_wr_idx = 3'(idx);
        out_wr_bit = val;
        step();
        out_wr_en  = 1'b0;
    endtask

    task automatic finish_exec();
        exec_done = 1'b1;
        step();
        exec_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_req = 0; fault_fatal = 0; comm_pending = 0; comm_done = 0;
        exec_done = 0; field_in = '0; in_rd_idx = 0; out_wr_idx = 0; out_rd_idx = 0;
        out_wr_en = 0; out_wr_bit = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R11 phase", 32'(phase_o), 32'(PH_IDLE));
        chk("R11 field_out", 32'(field_out), 32'h0);
        chk("R11 flags", {29'b0, wdog_alarm, fault_led, stop_by_wdog}, 32'h0);
        repeat (3) step();
        chk("R1 idle without run_req", 32'(phase_o), 32'(PH_IDLE));
    endtask

    task automatic t_order_images();
        field_in = 8'hA5;
        run_req  = 1'b1;
        step();
        chk("R1 selftest", 32'(phase_o), 32'(PH_SELFTEST));
        run_req = 1'b0;
        step();
        chk("R1 comm", 32'(phase_o), 32'(PH_COMM));
        chk("R2 no pending busy", 32'(comm_busy), 32'h0);
        step();
        chk("R2 comm skipped R1 input", 32'(phase_o), 32'(PH_INPUT));
        step();
        chk("R1 exec", 32'(phase_o), 32'(PH_EXEC));
        field_in = 8'h5A;
        for (int i = 0; i < NI; i++) begin
            in_rd_idx = 3'(i);
            #1;
            chk("R3 frozen image", 32'(in_rd_bit), 32'(8'hA5 >> i) & 32'h1);
        end
        for (int i = 0; i < NO; i++) begin
            write_bit(i, (8'h3C >> i) & 1);
            chk("R6 exec waits", 32'(phase_o), 32'(PH_EXEC));
        end
        for (int i = 0; i < NO; i++) begin
            out_rd_idx = 3'(i);
            #1;
            chk("R4 readback", 32'(out_rd_bit), 32'(8'h3C >> i) & 32'h1);
        end
        chk("R5 latch before refresh", 32'(field_out), 32'h0);
        finish_exec();
        chk("R1 output", 32'(phase_o), 32'(PH_OUTPUT));
        chk("R5 latch in output", 32'(field_out), 32'h0);
        out_wr_en = 1'b1; out_wr_idx = 3'd1; out_wr_bit = 1'b1;
        step();
        out_wr_en = 1'b0;
        chk("R1 wrap to selftest", 32'(phase_o), 32'(PH_SELFTEST));
        chk("R5 latch refreshed", 32'(field_out), 32'h3C);
    endtask

    task automatic t_comm();
        comm_pending = 1'b1;
        step();
        chk("R2 comm", 32'(phase_o), 32'(PH_COMM));
        chk("R2 busy", 32'(comm_busy), 32'h1);
        fault_fatal = 1'b1;
        out_wr_en = 1'b1; out_wr_idx = 3'd0; out_wr_bit = 1'b1;
        step();
        fault_fatal = 1'b0;
        out_wr_en   = 1'b0;
        chk("R2 comm holds", 32'(phase_o), 32'(PH_COMM));
        chk("R9 fault outside selftest", 32'(fault_led), 32'h0);
        step();
        chk("R2 comm holds 2", 32'(phase_o), 32'(PH_COMM));
        comm_done = 1'b1;
        step();
        comm_done = 1'b0;
        comm_pending = 1'b0;
        chk("R2 done to input", 32'(phase_o), 32'(PH_INPUT));
        step();
        chk("R9 still scanning", 32'(phase_o), 32'(PH_EXEC));
        for (int i = 0; i < NI; i++) begin
            in_rd_idx = 3'(i);
            #1;
            chk("R3 resampled image", 32'(in_rd_bit), 32'(8'h5A >> i) & 32'h1);
        end
        out_rd_idx = 3'd0;
        #1;
        chk("R4 write in comm ignored", 32'(out_rd_bit), 32'h0);
        out_rd_idx = 3'd1;
        #1;
        chk("R4 write in output ignored", 32'(out_rd_bit), 32'h0);
        for (int i = 0; i < NO; i++) write_bit(i, (8'h81 >> i) & 1);
        finish_exec();
        step();
        chk("R5 second refresh", 32'(field_out), 32'h81);
    endtask

    task automatic scan_exec(input int n, input bit poke7);
        step();
        step();
        step();
        chk("R1 exec reached", 32'(phase_o), 32'(PH_EXEC));
        if (poke7) begin
            write_bit(7, 1'b0);
            repeat (n - 2) step();
        end else begin
            repeat (n - 1) step();
        end
        finish_exec();
        chk("R6 exec released", 32'(phase_o), 32'(PH_OUTPUT));
        chk("R7 no alarm yet", 32'(wdog_alarm), 32'h0);
        step();
    endtask

    task automatic t_wdog();
        scan_exec(LIM - 4, 1'b0);
        chk("R7 limit-1 scan completes", 32'(phase_o), 32'(PH_SELFTEST));
        chk("R7 no alarm", 32'(wdog_alarm), 32'h0);
        scan_exec(LIM - 3, 1'b1);
        chk("R8 stop on overrun", 32'(phase_o), 32'(PH_STOP));
        chk("R8 alarm", 32'(wdog_alarm), 32'h1);
        chk("R8 cause", 32'(stop_by_wdog), 32'h1);
        chk("R8 refresh dropped", 32'(field_out), 32'h81);
    endtask

    task automatic t_stop();
        run_req = 1'b1;
        field_in = 8'hFF;
        out_wr_en = 1'b1; out_wr_idx = 3'd7; out_wr_bit = 1'b1;
        repeat (4) step();
        out_wr_en = 1'b0;
        chk("R10 stays stopped", 32'(phase_o), 32'(PH_STOP));
        chk("R10 latch held", 32'(field_out), 32'h81);
        out_rd_idx = 3'd7;
        #1;
        chk("R10 write ignored", 32'(out_rd_bit), 32'h0);
        run_req = 1'b0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R11 idle after reset", 32'(phase_o), 32'(PH_IDLE));
        chk("R11 alarm cleared", 32'(wdog_alarm), 32'h0);
        chk("R11 latch cleared", 32'(field_out), 32'h0);
        step();
        chk("R10 needs run_req", 32'(phase_o), 32'(PH_IDLE));
    endtask

    task automatic t_fault();
        run_req = 1'b1;
        step();
        run_req = 1'b0;
        step();
        step();
        step();
        chk("R1 exec after restart", 32'(phase_o), 32'(PH_EXEC));
        write_bit(0, 1'b1);
        write_bit(7, 1'b1);
        finish_exec();
        fault_fatal = 1'b1;
        step();
        chk("R5 refresh before fault", 32'(field_out), 32'h81);
        chk("R1 selftest", 32'(phase_o), 32'(PH_SELFTEST));
        step();
        fault_fatal = 1'b0;
        chk("R9 stop on fault", 32'(phase_o), 32'(PH_STOP));
        chk("R9 led", 32'(fault_led), 32'h1);
        chk("R9 cause", 32'(stop_by_wdog), 32'h0);
        chk("R9 no alarm", 32'(wdog_alarm), 32'h0);
        run_req = 1'b1;
        repeat (3) step();
        run_req = 1'b0;
        chk("R10 fault stop held", 32'(phase_o), 32'(PH_STOP));
        chk("R10 latch held", 32'(field_out), 32'h81);
    endtask

    initial begin
        t_reset();
        t_order_images();
        t_comm();
        t_wdog();
        t_stop();
        t_fault();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

endmodule